// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous host request port to an external asynchronous static RAM of 256K words by 8 bits. The host raises a request with a direction bit, an 18-bit word address and 8-bit write data. The controller then runs one complete memory cycle. Every phase of that cycle lasts a parameterised number of clock cycles, chosen so that the memory's minimum nanosecond timing holds at the chosen clock period. Read data returns with a one-cycle valid strobe.

The memory side has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable, a registered address, and a split data bus with separate out, drive-enable and in signals. All pins are driven from flip-flops. The address changes only when a request is accepted, so it never moves while the write strobe is low. After every access there is a fixed turnaround gap with the bus released. This keeps the controller's drivers and the memory's outputs from overlapping.

A sleep input puts the memory into low-power retention by pulling the active-high select low. When sleep is released, the controller keeps the memory deselected for one read-cycle time before it accepts work again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, host_ready=1, host_rvalid=0, mem_cs_n=1, mem_cs=1, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and mem_addr=0.
- R2: A read occupies RD_CYC (default 6) consecutive cycles starting the cycle after acceptance. In them mem_cs_n=0, mem_cs=1, mem_we_n=1, mem_oe_n=0 and mem_dq_oe=0. mem_dq_in is sampled at the clock edge that ends the last of them. In the next cycle host_rvalid=1 for exactly one cycle with that value on host_rdata.
- R3: A write occupies WR_CYC (default 6) consecutive cycles starting the cycle after acceptance. In them mem_cs_n=0, mem_cs=1, mem_oe_n=1, mem_dq_oe=1 and mem_dq_out holds the accepted data. mem_we_n=0 exactly in write cycles WE_START to WE_START+WE_LO_CYC-1, counted from 0 (defaults 1 to 4).
- R4: mem_addr takes host_addr in the cycle after acceptance and changes at no other time. In particular it is stable in every cycle that follows a cycle with mem_we_n=0.
- R5: host_ready is 1 exactly when the controller is idle and sleep_req is 0. A request is accepted only at a clock edge where host_req=1 and host_ready=1. A request raised and dropped while host_ready=0 has no effect on the memory.
- R6: After every read or write, TURN_CYC (default 2) cycles follow with every pin at its idle value and host_ready=0. mem_dq_oe is never 1 while mem_oe_n=0. mem_oe_n never falls unless mem_dq_oe was 0 in the two preceding cycles.
- R7: sleep_req=1 seen at an edge while idle makes mem_cs=0, with mem_cs_n=1, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0, from the next cycle on. If sleep_req and host_req are high in the same idle cycle, sleep wins and no access starts.
- R8: After sleep_req returns to 0, mem_cs stays 0 and host_ready stays 0 for WAKE_CYC (default 6) further cycles. If sleep_req rises again in that window, the controller goes back to sleep and the wait restarts from the beginning.
- R9: sleep_req raised during an access or its turnaround does not cut it short. The access completes, including host_rvalid for a read, and sleep is entered from idle afterwards.
- R10: While idle, mem_cs_n=1 (deselected) and mem_cs=1, and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller can accept a request |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read data strobe |
| sleep_req | input | 1 | Request retention/standby |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data from memory |

## Verification
The interesting collision is a sleep request and a host request in the same cycle. It happens both while idle and while an access is in flight. The bench raises sleep_req together with host_req in an idle cycle and expects the memory to drop into retention with no access started. The held request must then be taken only after the full wake-up wait. The bench also raises sleep_req one cycle into a read and expects the read, its data strobe and the turnaround to finish before the select falls. A behavioural reference model predicts every pin and host output each cycle, and each is compared against the design.

// File: rtl/asram_pkg.sv
// Shared types for the asynchronous SRAM access controller.
// Assumes: one access at a time; pin values are produced from these types
// and registered before leaving the block.
package asram_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_TURN  = 3'd3,
        ST_SLEEP = 3'd4,
        ST_WAKE  = 3'd5
    } seq_state_t;

    // Memory control pin bundle (levels as seen on the pins)
    typedef struct packed {
        logic sel_n;   // active-low select
        logic sel;     // active-high select
        logic wr_n;    // active-low write strobe
        logic rd_n;    // active-low output enable
        logic drive;   // controller drives the data pins
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE  = '{sel_n: 1'b1, sel: 1'b1, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};
    localparam pin_ctl_t PINS_SLEEP = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};

    // Largest of four cycle counts, used to size the phase counter
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/asram_cycle_timer.sv
// Phase counter: counts clock cycles spent in the current sequencer phase.
// Assumes: restart is pulsed by the sequencer on every phase change; the
// counter wraps harmlessly in phases that do not look at it.
module asram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    // Next count: zero on a phase change, otherwise one more
    always_comb begin
        cnt_d = restart ? '0 : cnt_q + CNT_W'(1);
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/asram_seq_fsm.sv
// Access sequencer: decides the phase of the memory cycle, the host
// handshake and the read-sample instant.
// Assumes: every *_CYC parameter is at least 1; the phase counter restarts
// whenever restart is high.
module asram_seq_fsm
    import asram_pkg::*;
#(
    parameter int RD_CYC   = 6,
    parameter int WR_CYC   = 6,
    parameter int TURN_CYC = 2,
    parameter int WAKE_CYC = 6,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             sleep_req,
    input  logic [CNT_W-1:0] cnt_q,
    output seq_state_t       state_q,
    output seq_state_t       state_d,
    output logic             restart,
    output logic             ready,
    output logic             accept,
    output logic             rd_done
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

    // Handshake: ready only when idle and no sleep pending
    always_comb begin
        ready   = (state_q == ST_IDLE) && !sleep_req;
        accept  = ready && host_req;
        rd_done = (state_q == ST_READ) && (cnt_q == RD_LAST);
    end

    // Next phase and counter restart
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    state_d = ST_SLEEP;
                    restart = 1'b1;
                end else if (host_req) begin
                    state_d = host_wr ? ST_WRITE : ST_READ;
                    restart = 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_q == RD_LAST) begin
                    state_d = ST_TURN;
                    restart = 1'b1;
                end
            end
            ST_WRITE: begin
                if (cnt_q == WR_LAST) begin
                    state_d = ST_TURN;
                    restart = 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_q == TURN_LAST) begin
                    state_d = ST_IDLE;
                    restart = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!sleep_req) begin
                    state_d = ST_WAKE;
                    restart = 1'b1;
                end
            end
            ST_WAKE: begin
                if (sleep_req) begin
                    state_d = ST_SLEEP;
                    restart = 1'b1;
                end else if (cnt_q == WAKE_LAST) begin
                    state_d = ST_IDLE;
                    restart = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                restart = 1'b1;
            end
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/asram_pin_drive.sv
// Memory pin stage: decodes the upcoming phase and count into pin levels
// and registers them, so every memory pin leaves the block from a flop.
// Address and write data are captured only on acceptance.
// Assumes: WE_START + WE_LO_CYC <= WR_CYC.
module asram_pin_drive
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 3,
    parameter int WE_START  = 1,
    parameter int WE_LO_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_d,
    input  logic [CNT_W-1:0]  cnt_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output pin_ctl_t          pins_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    localparam int WE_END = WE_START + WE_LO_CYC;

    pin_ctl_t pins_d;
    logic     strobe_win;

    // Write strobe window inside the write phase
    always_comb begin
        strobe_win = (int'(cnt_d) >= WE_START) && (int'(cnt_d) < WE_END);
    end

    // Pin levels for the phase that starts at the next edge
    always_comb begin
        pins_d = PINS_IDLE;
        unique case (state_d)
            ST_READ: begin
                pins_d.sel_n = 1'b0;
                pins_d.rd_n  = 1'b0;
            end
            ST_WRITE: begin
                pins_d.sel_n = 1'b0;
                pins_d.wr_n  = !strobe_win;
                pins_d.drive = 1'b1;
            end
            ST_SLEEP, ST_WAKE: pins_d = PINS_SLEEP;
            default:           pins_d = PINS_IDLE;
        endcase
    end

    // Control pin register
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= PINS_IDLE;
        else        pins_q <= pins_d;
    end

    // Address and write data capture at acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

endmodule

// File: rtl/asram_read_capture.sv
// Read return: samples the memory data pins at the end of the read phase
// and presents them to the host with a one-cycle valid strobe.
// Assumes: sample is high for exactly one cycle per read.
module asram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    // Capture read data and raise the strobe for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= sample;
            if (sample) rdata_q <= mem_dq_in;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
// Asynchronous SRAM access controller (top).
// Runs one read or write at a time on an external asynchronous SRAM with
// phase lengths given in clock cycles, adds a bus turnaround after each
// access, and handles a retention request with a wake-up wait.
// Assumes: cycle parameters are pre-rounded up from the memory's
// nanosecond limits at the clock in use (defaults: 100 MHz, 55 ns grade).
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int RD_CYC    = 6,
    parameter int WR_CYC    = 6,
    parameter int WE_START  = 1,
    parameter int WE_LO_CYC = 4,
    parameter int TURN_CYC  = 2,
    parameter int WAKE_CYC  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              sleep_req,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int MAX_CYC = max4(RD_CYC, WR_CYC, TURN_CYC, WAKE_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             restart;
    logic             accept;
    logic             rd_done;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    pin_ctl_t         pins_q;

    asram_cycle_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    asram_seq_fsm #(
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC),
        .WAKE_CYC (WAKE_CYC),
        .CNT_W    (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_wr   (host_wr),
        .sleep_req (sleep_req),
        .cnt_q     (cnt_q),
        .state_q   (state_q),
        .state_d   (state_d),
        .restart   (restart),
        .ready     (host_ready),
        .accept    (accept),
        .rd_done   (rd_done)
    );

    asram_pin_drive #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .WE_START  (WE_START),
        .WE_LO_CYC (WE_LO_CYC)
    ) i_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_d    (state_d),
        .cnt_d      (cnt_d),
        .accept     (accept),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .pins_q     (pins_q),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_out)
    );

    asram_read_capture #(
        .DATA_W (DATA_W)
    ) i_rcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (rd_done),
        .mem_dq_in (mem_dq_in),
        .rdata_q   (host_rdata),
        .rvalid_q  (host_rvalid)
    );

    // Unpack the registered control bundle onto the pins
    always_comb begin
        mem_cs_n  = pins_q.sel_n;
        mem_cs    = pins_q.sel;
        mem_we_n  = pins_q.wr_n;
        mem_oe_n  = pins_q.rd_n;
        mem_dq_oe = pins_q.drive;
    end

endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for the asynchronous SRAM access controller, bound to
// the top module. Observes ports only.
module asram_ctrl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    // R4
    addr_hold_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> $stable(mem_addr));

    // R3
    strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n && mem_dq_oe));

    // R6
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    oe_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!$past(mem_dq_oe, 1) && !$past(mem_dq_oe, 2)));

    // R2
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R10
    ready_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ready));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_cs_n    (mem_cs_n),
    .mem_cs      (mem_cs),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_oe   (mem_dq_oe),
    .mem_addr    (mem_addr)
);

// File: tb/test_asram_ctrl.sv
// Bench: behavioural cycle model compared with the design every cycle,
// plus directed checks on readback, wake-up wait and deferred sleep.
module test_asram_ctrl;

    localparam int PER = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [17:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        sleep_req = 1'b0;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [17:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(PER/2) clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sleep_req(sleep_req),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Device memory (indexed by low 6 address bits) and reference copy
    logic [7:0] dev_mem [64];
    logic [7:0] ref_mem [64];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 5 + 17);
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            dev_mem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
    end

    // Memory answers only in a proper read; otherwise a marker value
    always_comb begin
        if (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n)
            mem_dq_in = dev_mem[mem_addr[5:0]];
        else
            mem_dq_in = 8'hEE;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model: 0 idle, 1 read, 2 write, 3 turn, 4 sleep, 5 wake
    int         m_st = 0;
    int         m_cnt = 0;
    logic [17:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rdata = '0;
    bit          m_rv = 1'b0;

    always @(posedge clk) begin
        m_rv = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
        end else begin
            m_cnt = m_cnt + 1;
            case (m_st)
                0: if (sleep_req) begin m_st = 4; m_cnt = 0; end
                   else if (host_req) begin
                       m_addr = host_addr; m_wdata = host_wdata;
                       m_st = host_wr ? 2 : 1; m_cnt = 0;
                       if (host_wr) ref_mem[host_addr[5:0]] = host_wdata;
                   end
                1: if (m_cnt == 6) begin
                       m_rv = 1'b1; m_rdata = ref_mem[m_addr[5:0]];
                       m_st = 3; m_cnt = 0;
                   end
                2: if (m_cnt == 6) begin m_st = 3; m_cnt = 0; end
                3: if (m_cnt == 2) begin m_st = 0; m_cnt = 0; end
                4: if (!sleep_req) begin m_st = 5; m_cnt = 0; end
                5: if (sleep_req) begin m_st = 4; m_cnt = 0; end
                   else if (m_cnt == 6) begin m_st = 0; m_cnt = 0; end
                default: m_st = 0;
            endcase
        end
    end

    // Mid-cycle comparison and device write capture
    always begin
        @(negedge clk);
        #5;
        if (!mem_cs_n && mem_cs && !mem_we_n && mem_dq_oe)
            dev_mem[mem_addr[5:0]] = mem_dq_out;
        if (rst_n && !done) begin
            chk("R5", "host_ready", 32'(host_ready), 32'((m_st == 0) && !sleep_req));
            chk("R2", "host_rvalid", 32'(host_rvalid), 32'(m_rv));
            if (m_rv) chk("R2", "host_rdata", 32'(host_rdata), 32'(m_rdata));
            chk("R10", "mem_cs_n", 32'(mem_cs_n), 32'(!(m_st == 1 || m_st == 2)));
            chk("R7", "mem_cs", 32'(mem_cs), 32'(!(m_st == 4 || m_st == 5)));
            chk("R2", "mem_oe_n", 32'(mem_oe_n), 32'(m_st != 1));
            chk("R3", "mem_we_n", 32'(mem_we_n),
                32'(!(m_st == 2 && m_cnt >= 1 && m_cnt <= 4)));
            chk("R6", "mem_dq_oe", 32'(mem_dq_oe), 32'(m_st == 2));
            if (m_st == 2) chk("R3", "mem_dq_out", 32'(mem_dq_out), 32'(m_wdata));
            chk("R4", "mem_addr", 32'(mem_addr), 32'(m_addr));
        end
    end

    // Issue one request and hold it until it is taken
    task automatic do_op(input bit wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        forever begin
            #1;
            if (host_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        host_req = 1'b0;
    endtask

    // Read and compare the returned byte against an expected value
    task automatic rd_expect(input logic [17:0] a, input logic [7:0] e, input string tag);
        bit seen;
        seen = 1'b0;
        do_op(1'b0, a, 8'h00);
        for (int k = 0; k < 12 && !seen; k++) begin
            #1;
            if (host_rvalid) begin
                seen = 1'b1;
                chk(tag, "readback", 32'(host_rdata), 32'(e));
            end else begin
                @(negedge clk);
            end
        end
        if (!seen) chk(tag, "rvalid seen", 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "ready", 32'(host_ready), 1);
        chk("R1", "rvalid", 32'(host_rvalid), 0);
        chk("R1", "pins", {27'd0, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b11110);
        chk("R1", "addr", 32'(mem_addr), 0);

        // R3 writes at both address extremes, R2 readback
        do_op(1'b1, 18'h00005, 8'hA5);
        do_op(1'b1, 18'h3FFFF, 8'h3C);
        rd_expect(18'h00005, 8'hA5, "R2");
        rd_expect(18'h3FFFF, 8'h3C, "R2");
        rd_expect(18'h00012, init_val(18), "R2");

        // Back-to-back mixed traffic (R4, R6)
        for (int i = 0; i < 6; i++)
            do_op(i[0], 18'(i * 18'h01001 + 8), 8'(i * 37 + 1));

        // R5 request while busy is not taken
        do_op(1'b1, 18'h00007, 8'h11);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 18'h00021; host_wdata = 8'h77;
        repeat (3) @(negedge clk);
        host_req = 1'b0;
        repeat (10) @(negedge clk);
        rd_expect(18'h00021, init_val(33), "R5");

        // R7 sleep and request in the same idle cycle: sleep wins
        @(negedge clk);
        sleep_req = 1'b1;
        host_req = 1'b1; host_wr = 1'b1; host_addr = 18'h00030; host_wdata = 8'h5A;
        repeat (8) @(negedge clk);
        #1;
        chk("R7", "cs in sleep", 32'(mem_cs), 0);
        @(negedge clk);
        sleep_req = 1'b0;
        // R8 wake-up wait
        repeat (6) @(negedge clk);
        #1;
        chk("R8", "ready during wake", 32'(host_ready), 0);
        @(negedge clk);
        #1;
        chk("R8", "ready after wake", 32'(host_ready), 1);
        @(negedge clk);
        host_req = 1'b0;
        repeat (10) @(negedge clk);
        rd_expect(18'h00030, 8'h5A, "R7");

        // R8 sleep re-raised during wake restarts the wait
        @(negedge clk);
        sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        sleep_req = 1'b1;
        repeat (2) @(negedge clk);
        sleep_req = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk("R8", "ready after restarted wake", 32'(host_ready), 0);
        repeat (4) @(negedge clk);

        // R9 sleep during a read: the read still completes
        do_op(1'b0, 18'h00005, 8'h00);
        sleep_req = 1'b1;
        got = 1'b0;
        for (int k = 0; k < 12 && !got; k++) begin
            #1;
            if (host_rvalid) begin
                got = 1'b1;
                chk("R9", "deferred read data", 32'(host_rdata), 32'hA5);
            end else begin
                @(negedge clk);
            end
        end
        chk("R9", "read completed", 32'(got), 1);
        repeat (5) @(negedge clk);
        #1;
        chk("R9", "sleep entered after access", 32'(mem_cs), 0);
        @(negedge clk);
        sleep_req = 1'b0;
        repeat (10) @(negedge clk);
        rd_expect(18'h3FFFF, 8'h3C, "R9");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule